// File: doc/BRIEF.md
# Flywheel Bit-Clock Recovery and Data Retimer

This block takes the sliced receive bit stream of a tone modem (the raw,
unclocked demodulator output) and derives a bit clock from its transitions.
A phase counter runs through one bit period and is pulled toward the
transitions by a fixed step each time an edge arrives. It keeps counting at
the nominal rate when no edges come, so the recovered clock coasts across
runs of identical bits. The counter drives a clean square-wave sync output.
The same counter's midpoint retimes the data into a registered output.

The bit rate follows the usual modem strap pins: a 1200/2400 select, a 4800
select and a master-clock-rate select. The master clock runs either at
840 x 1200 Hz or at four times that. A receive enable acts as a power-save
control and forces the outputs to fixed levels while it is low.

Top module: `fwclk_recovery`

## Requirements
- R1: While reset is asserted, the phase counter is 0, and `rx_sync` and `rx_data_q` are 0.
- R2: With `clk_rate_hi`=0, `baud_1200_sel`=1 and no input edges, `rx_sync` has a period of 840 clocks. It is high for exactly the second half (420 clocks), and it rises when the phase reaches 420.
- R3: The rate decodes as follows. If `baud_1200_sel`=1, the rate is 1200 baud (phase +1 per tick). If `baud_1200_sel`=0 with `baud_4800_sel`=1 and `clk_rate_hi`=1, the rate is 4800 baud (+4 per tick). Every other setting gives 2400 baud (+2 per tick). A tick occurs on every clock when `clk_rate_hi`=0 and on every 4th clock when it is 1. This gives free-running periods of 840, 420, 3360, 1680 and 840 clocks for 1200/base, 2400/base, 1200/fast, 2400/fast and 4800/fast.
- R4: With `clk_rate_hi`=0, `baud_4800_sel` has no effect, so 4800 requested at the base clock runs at 2400 (period 420).
- R5: An input change is seen as an edge 3 clocks later, after a two-flop synchroniser and an edge flop. On that clock the correction replaces the normal advance. If the phase is at least 420 and more than 52 below 840, it moves forward by 52. If it is below 420 and above 52, it moves back by 52.
- R6: An edge seen when the phase is within 52 of the ideal transition point (phase at most 52, or within 52 of 840) sets the phase to 0.
- R7: `rx_data_q` loads the synchronised input bit only on the clock where `rx_sync` rises, and holds it otherwise.
- R8: While `rx_en`=0, `rx_sync` is 0, and `rx_data_q` is 0 from the next clock on. The phase is held at 0 and input edges have no effect.
- R9: After `rx_en` rises, the phase counts up from 0. The first `rx_sync` rise follows 420 ticks later, and `rx_data_q` stays 0 until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_rate_hi | input | 1 | 1: master clock is the fast (x4) rate |
| baud_1200_sel | input | 1 | 1: 1200 baud; 0: 2400 or 4800 |
| baud_4800_sel | input | 1 | With the line above at 0 and fast clock: 4800 baud |
| rx_en | input | 1 | Receive enable; 0 is power save |
| rx_bit_in | input | 1 | Sliced, unclocked receive data |
| rx_sync | output | 1 | Recovered bit clock, rising at mid-bit |
| rx_data_q | output | 1 | Receive data retimed by the recovered clock |

## Verification
A constant input separates the rate decodes from one another by the free-running period, including the 4800-at-base-clock case. Single edges placed early in the bit, late in the bit and near the transition point tell the retard, advance and snap corrections apart by how far the next sync edge moves. A data pattern changing at each bit boundary shows the retimed output catching each bit at mid-bit. Long alternating streams slightly faster and slower than nominal stress the tracking against the reference model. Power-save toggling and enable release check the forced levels and the restart timing.

// File: rtl/fwclk_pkg.sv
package fwclk_pkg;

  typedef enum logic [1:0] {
    BR_2400 = 2'd0,
    BR_1200 = 2'd1,
    BR_4800 = 2'd2
  } baud_e;

  // Strap decode: the 4800 rate needs the fast master clock.
  function automatic baud_e pick_baud(input logic sel_1200,
                                      input logic sel_4800,
                                      input logic fast_clk);
    if (sel_1200)                 return BR_1200;
    else if (sel_4800 && fast_clk) return BR_4800;
    else                          return BR_2400;
  endfunction

  // Phase advance per tick for a given rate.
  function automatic logic [2:0] baud_inc(input baud_e b);
    case (b)
      BR_1200: return 3'd1;
      BR_4800: return 3'd4;
      default: return 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/fwclk_insync.sv
module fwclk_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic edge_p
);

  // chain_q[0] is the newest sample; chain_q[STAGES] is the edge reference.
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  assign chain_d[0] = din;
  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    assign chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout   = chain_q[STAGES-1];
  assign edge_p = chain_q[STAGES-1] ^ chain_q[STAGES];

endmodule

// File: rtl/fwclk_tickgen.sv
module fwclk_tickgen
  import fwclk_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       fast_clk,
  input  logic       sel_1200,
  input  logic       sel_4800,
  output logic       tick,
  output logic [2:0] inc
);

  localparam int CW = $clog2(PRESCALE);
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] pre_q, pre_d;
  baud_e         rate;

  always_comb begin
    if (!en || !fast_clk)  pre_d = '0;
    else if (pre_q == LAST) pre_d = '0;
    else                   pre_d = pre_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign rate = pick_baud(sel_1200, sel_4800, fast_clk);
  assign inc  = baud_inc(rate);
  assign tick = !fast_clk || (pre_q == LAST);

endmodule

// File: rtl/fwclk_phase.sv
module fwclk_phase #(
  parameter int PER        = 840,
  parameter int STEP_SHIFT = 4,
  localparam int PW        = $clog2(PER)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [2:0]    inc,
  input  logic          edge_p,
  output logic [PW-1:0] phase_q,
  output logic          mid_cross
);

  localparam logic [PW:0]   PER_V  = (PW+1)'(PER);
  localparam logic [PW:0]   STEP_V = (PW+1)'(PER >> STEP_SHIFT);
  localparam logic [PW-1:0] HALF_V = PW'(PER / 2);

  logic [PW-1:0] phase_d;
  logic [PW:0]   ph_w;
  logic [PW:0]   adv;
  logic [PW:0]   to_wrap;

  assign ph_w    = {1'b0, phase_q};
  assign adv     = ph_w + {{(PW-2){1'b0}}, inc};
  assign to_wrap = PER_V - ph_w;

  always_comb begin
    phase_d = phase_q;
    if (!en) begin
      phase_d = '0;
    end else if (edge_p) begin
      if (phase_q < HALF_V) begin
        // edge came late: pull back toward the transition
        if (ph_w > STEP_V) phase_d = PW'(ph_w - STEP_V);
        else               phase_d = '0;
      end else begin
        // edge came early: push forward toward the wrap
        if (to_wrap > STEP_V) phase_d = PW'(ph_w + STEP_V);
        else                  phase_d = '0;
      end
    end else if (tick) begin
      if (adv >= PER_V) phase_d = PW'(adv - PER_V);
      else              phase_d = PW'(adv);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign mid_cross = en && (phase_q < HALF_V) && (phase_d >= HALF_V);

endmodule

// File: rtl/fwclk_recovery.sv
module fwclk_recovery #(
  parameter int PER         = 840,
  parameter int STEP_SHIFT  = 4,
  parameter int PRESCALE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_rate_hi,
  input  logic baud_1200_sel,
  input  logic baud_4800_sel,
  input  logic rx_en,
  input  logic rx_bit_in,
  output logic rx_sync,
  output logic rx_data_q
);

  localparam int PW = $clog2(PER);
  localparam logic [PW-1:0] HALF_V = PW'(PER / 2);

  logic          bit_s;
  logic          edge_p;
  logic          tick;
  logic [2:0]    inc;
  logic [PW-1:0] ph_now;
  logic          mid_cross;
  logic          dq_d;

  fwclk_insync #(.STAGES(SYNC_STAGES)) u_insync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (rx_bit_in),
    .dout   (bit_s),
    .edge_p (edge_p)
  );

  fwclk_tickgen #(.PRESCALE(PRESCALE)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (rx_en),
    .fast_clk (clk_rate_hi),
    .sel_1200 (baud_1200_sel),
    .sel_4800 (baud_4800_sel),
    .tick     (tick),
    .inc      (inc)
  );

  fwclk_phase #(.PER(PER), .STEP_SHIFT(STEP_SHIFT)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (rx_en),
    .tick      (tick),
    .inc       (inc),
    .edge_p    (edge_p),
    .phase_q   (ph_now),
    .mid_cross (mid_cross)
  );

  always_comb begin
    if (!rx_en)         dq_d = 1'b0;
    else if (mid_cross) dq_d = bit_s;
    else                dq_d = rx_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_data_q <= 1'b0;
    else        rx_data_q <= dq_d;
  end

  assign rx_sync = rx_en && (ph_now >= HALF_V);

endmodule

// File: rtl/fwclk_recovery_chk.sv
module fwclk_recovery_chk #(
  parameter int PER  = 840,
  parameter int STEP = 52,
  localparam int PW  = $clog2(PER)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          rx_sync,
  input logic          rx_data_q,
  input logic [PW-1:0] phase
);

  localparam logic [PW:0] PER_V  = (PW+1)'(PER);
  localparam logic [PW:0] STEP_V = (PW+1)'(STEP);

  logic [PW-1:0] prev_ph;
  logic [PW:0]   raw_mv;
  logic [PW:0]   mv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_ph <= '0;
    else        prev_ph <= phase;
  end

  // forward distance moved since last clock, modulo one bit period
  assign raw_mv = {1'b0, phase} + PER_V - {1'b0, prev_ph};
  assign mv     = (raw_mv >= PER_V) ? raw_mv - PER_V : raw_mv;

  a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, phase} < PER_V);

  a_r5_move_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_en) |-> (mv <= STEP_V || mv >= PER_V - STEP_V));

  a_r7_data_only_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && $past(rx_en) && (rx_data_q != $past(rx_data_q))) |-> $rose(rx_sync));

  a_r8_sync_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !rx_sync);

  a_r8_data_cleared_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_data_q);

  a_r9_phase_cleared_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (phase == '0));

endmodule

bind fwclk_recovery fwclk_recovery_chk #(
  .PER  (PER),
  .STEP (PER >> STEP_SHIFT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .rx_sync   (rx_sync),
  .rx_data_q (rx_data_q),
  .phase     (ph_now)
);

// File: tb/sim_fwclk_recovery.sv
`timescale 1ns/1ps
module sim_fwclk_recovery;

  localparam int PER  = 840;
  localparam int HALF = 420;
  localparam int STEP = 52;

  logic clk = 1'b0;
  logic rst_n;
  logic rate_hi, b1200, b4800, rx_en, rx_bit;
  logic rx_sync, rx_data_q;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  fwclk_recovery u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .clk_rate_hi   (rate_hi),
    .baud_1200_sel (b1200),
    .baud_4800_sel (b4800),
    .rx_en         (rx_en),
    .rx_bit_in     (rx_bit),
    .rx_sync       (rx_sync),
    .rx_data_q     (rx_data_q)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // ---------------- behavioural reference ----------------
  bit hist[$];       // input samples, newest at front
  int m_pre = 0;
  int m_ph  = 0;
  int m_dq  = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_pre = 0; m_ph = 0; m_dq = 0;
    end else begin
      int step_in, nph;
      bit seen_edge, do_tick;
      step_in   = b1200 ? 1 : ((b4800 && rate_hi) ? 4 : 2);
      seen_edge = (hist[1] != hist[2]);
      do_tick   = rate_hi ? (m_pre == 3) : 1'b1;
      if (!rx_en)              nph = 0;
      else if (seen_edge) begin
        if (m_ph < HALF)       nph = (m_ph > STEP) ? m_ph - STEP : 0;
        else                   nph = (PER - m_ph > STEP) ? m_ph + STEP : 0;
      end else if (do_tick)    nph = (m_ph + step_in) % PER;
      else                     nph = m_ph;
      if (!rx_en)                               m_dq = 0;
      else if (m_ph < HALF && nph >= HALF)      m_dq = hist[1];
      m_pre = (!rx_en || !rate_hi) ? 0 : (m_pre + 1) % 4;
      m_ph  = nph;
      hist.push_front(rx_bit);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk(rx_sync == (rx_en && m_ph >= HALF), "R2 model sync", rx_sync, int'(rx_en && m_ph >= HALF));
      chk(rx_data_q == m_dq[0], "R7 model data", rx_data_q, m_dq);
    end
  end

  // ---------------- helpers ----------------
  task automatic next_rise(output int t);
    logic p;
    p = rx_sync;
    forever begin
      @(negedge clk);
      if (rx_sync && !p) break;
      p = rx_sync;
    end
    t = cyc;
  endtask

  task automatic next_fall(output int t);
    logic p;
    p = rx_sync;
    forever begin
      @(negedge clk);
      if (!rx_sync && p) break;
      p = rx_sync;
    end
    t = cyc;
  endtask

  task automatic period_of(input logic r, input logic s12, input logic s48,
                           input int exp, input string tag);
    int a, b;
    @(negedge clk);
    rate_hi = r; b1200 = s12; b4800 = s48;
    next_rise(a);
    next_rise(a);
    next_rise(b);
    chk(b - a == exp, tag, b - a, exp);
  endtask

  initial begin
    int t0, t1;
    bit quiet;
    rst_n = 1'b0; rate_hi = 1'b0; b1200 = 1'b1; b4800 = 1'b0;
    rx_en = 1'b1; rx_bit = 1'b0;
    repeat (5) @(negedge clk);
    chk(rx_sync == 1'b0, "R1 sync in reset", rx_sync, 0);
    chk(rx_data_q == 1'b0, "R1 data in reset", rx_data_q, 0);
    rst_n = 1'b1;

    // R2: free-running at 1200, base clock
    next_rise(t0);
    next_fall(t1);
    chk(t1 - t0 == HALF, "R2 high time", t1 - t0, HALF);
    next_rise(t1);
    chk(t1 - t0 == PER, "R2 period", t1 - t0, PER);

    // R3 / R4: rate decode
    period_of(1'b0, 1'b0, 1'b0, 420,  "R3 2400 base");
    period_of(1'b1, 1'b1, 1'b0, 3360, "R3 1200 fast");
    period_of(1'b1, 1'b0, 1'b0, 1680, "R3 2400 fast");
    period_of(1'b1, 1'b0, 1'b1, 840,  "R3 4800 fast");
    period_of(1'b0, 1'b0, 1'b1, 420,  "R4 4800 at base clock");
    period_of(1'b0, 1'b1, 1'b0, 840,  "R2 back to 1200");

    // R5: early-arriving edge in the second half advances the phase
    next_rise(t0);
    repeat (100) @(negedge clk);
    rx_bit = ~rx_bit;
    next_rise(t1);
    chk(t1 - t0 == 789, "R5 advance", t1 - t0, 789);

    // R5: late edge in the first half retards the phase
    next_fall(t0);
    repeat (200) @(negedge clk);
    rx_bit = ~rx_bit;
    next_rise(t1);
    chk(t1 - t0 == 473, "R5 retard", t1 - t0, 473);

    // R6: edge close to the transition snaps the phase to zero
    next_fall(t0);
    repeat (10) @(negedge clk);
    rx_bit = ~rx_bit;
    next_rise(t1);
    chk(t1 - t0 == 433, "R6 snap", t1 - t0, 433);

    // R7: data changing at bit boundaries is caught at mid-bit
    for (int i = 0; i < 16; i++) begin
      logic bv;
      bv = 1'((16'hB271 >> i) & 1);
      next_fall(t0);
      rx_bit = bv;
      next_rise(t1);
      chk(rx_data_q == bv, "R7 retimed bit", rx_data_q, bv);
    end

    // R5: tracking fast and slow alternating streams (model compare)
    for (int i = 0; i < 20; i++) begin
      rx_bit = ~rx_bit;
      repeat (806) @(negedge clk);
    end
    for (int i = 0; i < 20; i++) begin
      rx_bit = ~rx_bit;
      repeat (872) @(negedge clk);
    end

    // R8: power save
    rx_bit = 1'b1;
    next_rise(t0);
    next_rise(t0);
    chk(rx_data_q == 1'b1, "R7 data high before power save", rx_data_q, 1);
    rx_en = 1'b0;
    @(negedge clk);
    quiet = 1'b1;
    for (int i = 0; i < 60; i++) begin
      if (i % 7 == 0) rx_bit = ~rx_bit;
      @(negedge clk);
      if (rx_sync || rx_data_q) quiet = 1'b0;
    end
    chk(quiet, "R8 outputs held low", int'(!quiet), 0);

    // R9: restart after enable
    rx_bit = 1'b1;
    repeat (5) @(negedge clk);
    rx_en = 1'b1;
    quiet = 1'b1;
    t0 = 0;
    forever begin
      @(negedge clk);
      t0++;
      if (rx_sync) break;
      if (rx_data_q) quiet = 1'b0;
      if (t0 > 5000) break;
    end
    chk(t0 == HALF, "R9 first rise", t0, HALF);
    chk(quiet, "R9 data zero before first rise", int'(!quiet), 0);
    chk(rx_data_q == 1'b1, "R9 data at first rise", rx_data_q, 1);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule